// File: doc/BRIEF.md
# Low-Power Mode Select and Status Register

This block is a single memory-mapped control and status word. It tells the power sequencer which low-power state to request when the processor runs a wait-for-interrupt instruction. Software writes a three-bit mode code and may set a sticky lock that forbids the deepest state. When the processor reports a WFI, the block combines the mode code with the processor's SLEEPDEEP output and raises exactly one request line: plain sleep, deep-sleep, power-down or deep power-down. The request stays high until a wake-up event returns the block to active.

Two entry flags record what happened, and software clears them by writing ones. The lock bit and the deep power-down flag live in a retention domain that only the power-on reset initialises. The system reset clears the rest of the state. Reserved bits read as zero, and writes to them do nothing.

Top module: `pmu_mode_ctl`

## Requirements
- R1: After power-on reset the register reads 0x0000_0000 and all four request outputs are low.
- R2: The mode field sits at bits 2:0 and reads back what was last written. When the block is active and a WFI pulse arrives with SLEEPDEEP high, mode 1 raises req_deepsleep, mode 2 raises req_powerdown and mode 3 raises req_dpd (when unlocked). The request is high in the cycle after the WFI clock edge.
- R3: A WFI with SLEEPDEEP low raises req_sleep for any mode value. A WFI with SLEEPDEEP high and mode 0, 4, 5, 6 or 7 also raises req_sleep.
- R4: The lock bit is bit 3. Writing 1 sets it and writing 0 leaves it unchanged. The system reset does not clear it; only the power-on reset does.
- R5: With the lock set, a WFI with SLEEPDEEP high and mode 3 raises req_sleep instead of req_dpd and leaves the deep power-down flag unchanged. The lock does not alter modes 1 and 2.
- R6: The sleep flag is bit 8. It becomes 1 on any entry that raises req_sleep, req_deepsleep or req_powerdown. Writing 1 to bit 8 clears it and writing 0 has no effect.
- R7: The deep power-down flag is bit 11. It becomes 1 on an entry that raises req_dpd. Writing 1 to bit 11 clears it and writing 0 has no effect.
- R8: If a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up 1.
- R9: Bits 7:4, 10:9 and 31:12 always read 0, and writes to them are ignored. A read at any address other than REG_ADDR returns 0.
- R10: A wake-up event drives all requests low in the next cycle and leaves both flags as they were. A WFI in the same cycle as a wake-up event, or while a request is already high, is ignored.
- R11: At most one request output is high at any time.
- R12: The system reset clears the mode field, the sleep flag and all requests. It keeps the lock bit and the deep power-down flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; resets everything |
| sys_rst_n | input | 1 | System reset, synchronous, active low; leaves the retention bits |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | DATA_W | Register bus write data |
| bus_we | input | 1 | Register bus write strobe |
| bus_rdata | output | DATA_W | Register bus read data, combinational from bus_addr |
| wfi_pulse | input | 1 | One-cycle pulse: the processor executed WFI |
| sleepdeep | input | 1 | The processor's SLEEPDEEP control bit |
| wake_evt | input | 1 | Wake-up event |
| req_sleep | output | 1 | Plain sleep request |
| req_deepsleep | output | 1 | Deep-sleep request |
| req_powerdown | output | 1 | Power-down request |
| req_dpd | output | 1 | Deep power-down request |

## Verification
Register writes, WFI pulses, wake-up events and resets all take effect at the next rising edge. Requests and flags therefore change exactly one cycle after their stimulus, while reads are combinational. The bench drives every input on a falling edge and samples on the following falling edge, after exactly one rising edge, so each check lands on the first cycle in which its result is due. It sweeps every mode code with both SLEEPDEEP values and with the lock clear and set. It also places the colliding events (set against clear, WFI against wake-up, WFI during a request) in one shared cycle and checks the outcome in the cycle that follows.

// File: rtl/pmu_mode_pkg.sv
// Package: shared encodings for the low-power mode register.
// Assumes one 32-bit-class word; bit positions below are decoded by software.
package pmu_mode_pkg;

    // Request state; ACTIVE means no request is raised.
    typedef enum logic [2:0] {
        PM_ACTIVE = 3'd0,
        PM_SLEEP  = 3'd1,
        PM_DSLEEP = 3'd2,
        PM_PDOWN  = 3'd3,
        PM_DPD    = 3'd4
    } pm_state_e;

    localparam int MODE_W   = 3;
    localparam int MODE_LSB = 0;
    localparam int LOCK_BIT = 3;
    localparam int SLPF_BIT = 8;
    localparam int DPDF_BIT = 11;
    localparam int USED_MSB = DPDF_BIT;

    localparam logic [MODE_W-1:0] ENC_DSLEEP = 3'd1;
    localparam logic [MODE_W-1:0] ENC_PDOWN  = 3'd2;
    localparam logic [MODE_W-1:0] ENC_DPD    = 3'd3;

endpackage

// File: rtl/pmu_mode_decode.sv
// Module: pmu_mode_decode
// Purpose: maps mode code, SLEEPDEEP and lock onto the target low-power state.
// Assumes: purely combinational; unknown mode codes fall back to plain sleep.
module pmu_mode_decode
    import pmu_mode_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              sleepdeep,
    input  logic              lock,
    output pm_state_e         target
);

    // Select the target state for the next WFI.
    always_comb begin
        target = PM_SLEEP;
        if (sleepdeep) begin
            unique case (mode)
                ENC_DSLEEP: target = PM_DSLEEP;
                ENC_PDOWN:  target = PM_PDOWN;
                ENC_DPD:    target = lock ? PM_SLEEP : PM_DPD;
                default:    target = PM_SLEEP;
            endcase
        end
    end

endmodule

// File: rtl/pmu_mode_fsm.sv
// Module: pmu_mode_fsm
// Purpose: holds the current request state and emits entry pulses.
// Assumes: WFI is accepted only from active; wake-up dominates a same-cycle WFI.
module pmu_mode_fsm
    import pmu_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wfi,
    input  logic      wake,
    input  pm_state_e target,
    output logic      enter_slp,
    output logic      enter_dpd,
    output logic      req_sleep,
    output logic      req_deepsleep,
    output logic      req_powerdown,
    output logic      req_dpd
);

    pm_state_e state_q;
    logic      accept;

    // Decide whether this cycle's WFI starts a low-power entry.
    always_comb begin
        accept    = rst_n && wfi && !wake && (state_q == PM_ACTIVE);
        enter_dpd = accept && (target == PM_DPD);
        enter_slp = accept && (target != PM_DPD);
    end

    // Advance the request state: reset and wake to active, accepted WFI to target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_ACTIVE;
        end else if (wake) begin
            state_q <= PM_ACTIVE;
        end else if (accept) begin
            state_q <= target;
        end
    end

    // Drive one request line per non-active state.
    always_comb begin
        req_sleep     = (state_q == PM_SLEEP);
        req_deepsleep = (state_q == PM_DSLEEP);
        req_powerdown = (state_q == PM_PDOWN);
        req_dpd       = (state_q == PM_DPD);
    end

endmodule

// File: rtl/pmu_mode_regs.sv
// Module: pmu_mode_regs
// Purpose: storage for mode, lock and the two entry flags, plus the read word.
// Assumes: wr_en is already address-decoded and gated by both resets;
//          lock and DPD flag are in the retention domain (power-on reset only).
module pmu_mode_regs
    import pmu_mode_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_any_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              wr_lock,
    input  logic              wr_clr_slp,
    input  logic              wr_clr_dpd,
    input  logic              set_slp,
    input  logic              set_dpd,
    output logic [MODE_W-1:0] mode_q,
    output logic              lock_q,
    output logic              slp_flag_q,
    output logic              dpd_flag_q,
    output logic [DATA_W-1:0] rd_word
);

    // Mode field: reset by either reset, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_any_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_mode;
        end
    end

    // Lock: set-only by software, cleared solely by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lock_q <= 1'b0;
        end else if (wr_en && wr_lock) begin
            lock_q <= 1'b1;
        end
    end

    // Sleep flag: hardware set beats write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_any_n) begin
            slp_flag_q <= 1'b0;
        end else if (set_slp) begin
            slp_flag_q <= 1'b1;
        end else if (wr_en && wr_clr_slp) begin
            slp_flag_q <= 1'b0;
        end
    end

    // Deep power-down flag: retained over system reset, set beats clear.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            dpd_flag_q <= 1'b0;
        end else if (set_dpd) begin
            dpd_flag_q <= 1'b1;
        end else if (wr_en && wr_clr_dpd) begin
            dpd_flag_q <= 1'b0;
        end
    end

    // Assemble the read word; every unlisted bit is zero.
    always_comb begin
        rd_word                          = '0;
        rd_word[MODE_LSB +: MODE_W]      = mode_q;
        rd_word[LOCK_BIT]                = lock_q;
        rd_word[SLPF_BIT]                = slp_flag_q;
        rd_word[DPDF_BIT]                = dpd_flag_q;
    end

endmodule

// File: rtl/pmu_mode_ctl.sv
// Module: pmu_mode_ctl (top)
// Purpose: low-power mode select register with sticky DPD lock and W1C flags.
// Assumes: single-cycle register bus with combinational reads; DATA_W > DPDF_BIT.
module pmu_mode_ctl
    import pmu_mode_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wfi_pulse,
    input  logic              sleepdeep,
    input  logic              wake_evt,
    output logic              req_sleep,
    output logic              req_deepsleep,
    output logic              req_powerdown,
    output logic              req_dpd
);

    localparam int RSV_LO_W = SLPF_BIT - LOCK_BIT - 1;
    localparam int RSV_MI_W = DPDF_BIT - SLPF_BIT - 1;
    localparam int RSV_HI_W = DATA_W - USED_MSB - 1;

    logic              rst_any_n;
    logic              hit;
    logic              wr_en;
    logic [MODE_W-1:0] mode_q;
    logic              lock_q;
    logic              slp_flag_q;
    logic              dpd_flag_q;
    logic [DATA_W-1:0] rd_word;
    logic              enter_slp;
    logic              enter_dpd;
    pm_state_e         target;
    logic              unused_wbits;

    // Combine resets and decode the bus access.
    always_comb begin
        rst_any_n = por_n && sys_rst_n;
        hit       = (bus_addr == REG_ADDR);
        wr_en     = bus_we && hit && rst_any_n;
        bus_rdata = hit ? rd_word : '0;
    end

    // Reserved write bits are dropped on purpose.
    assign unused_wbits = ^{bus_wdata[DATA_W-1 -: RSV_HI_W],
                            bus_wdata[SLPF_BIT+1 +: RSV_MI_W],
                            bus_wdata[LOCK_BIT+1 +: RSV_LO_W]};

    pmu_mode_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .rst_any_n  (rst_any_n),
        .wr_en      (wr_en),
        .wr_mode    (bus_wdata[MODE_LSB +: MODE_W]),
        .wr_lock    (bus_wdata[LOCK_BIT]),
        .wr_clr_slp (bus_wdata[SLPF_BIT]),
        .wr_clr_dpd (bus_wdata[DPDF_BIT]),
        .set_slp    (enter_slp),
        .set_dpd    (enter_dpd),
        .mode_q     (mode_q),
        .lock_q     (lock_q),
        .slp_flag_q (slp_flag_q),
        .dpd_flag_q (dpd_flag_q),
        .rd_word    (rd_word)
    );

    pmu_mode_decode u_decode (
        .mode      (mode_q),
        .sleepdeep (sleepdeep),
        .lock      (lock_q),
        .target    (target)
    );

    pmu_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_any_n),
        .wfi           (wfi_pulse),
        .wake          (wake_evt),
        .target        (target),
        .enter_slp     (enter_slp),
        .enter_dpd     (enter_dpd),
        .req_sleep     (req_sleep),
        .req_deepsleep (req_deepsleep),
        .req_powerdown (req_powerdown),
        .req_dpd       (req_dpd)
    );

endmodule

// File: rtl/pmu_mode_ctl_chk.sv
// Module: pmu_mode_ctl_chk
// Purpose: temporal checks on the mode register, bound into pmu_mode_ctl.
// Assumes: sampled on the rising edge; disabled while the relevant reset is low.
module pmu_mode_ctl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       sys_rst_n,
    input logic       wfi_pulse,
    input logic       sleepdeep,
    input logic       wake_evt,
    input logic [2:0] mode_q,
    input logic       lock_q,
    input logic       slp_flag_q,
    input logic       dpd_flag_q,
    input logic       req_sleep,
    input logic       req_deepsleep,
    input logic       req_powerdown,
    input logic       req_dpd
);

    logic idle;
    assign idle = !(req_sleep || req_deepsleep || req_powerdown || req_dpd);

    p_onehot_req_r11: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        $onehot0({req_sleep, req_deepsleep, req_powerdown, req_dpd}));

    p_wake_drops_r10: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        wake_evt |=> idle);

    p_plain_sleep_r3: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (wfi_pulse && !sleepdeep && !wake_evt && idle) |=> req_sleep);

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |=> lock_q);

    p_dpd_blocked_r5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (lock_q && wfi_pulse && sleepdeep && mode_q == 3'd3 && !wake_evt && idle)
        |=> (req_sleep && !req_dpd));

    p_dpdflag_entry_r7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        $rose(dpd_flag_q) |-> req_dpd);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (wfi_pulse && !sleepdeep && !wake_evt && idle) |=> slp_flag_q);

    p_sysrst_keeps_r12: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && dpd_flag_q) |=> dpd_flag_q);

endmodule

bind pmu_mode_ctl pmu_mode_ctl_chk u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .sys_rst_n     (sys_rst_n),
    .wfi_pulse     (wfi_pulse),
    .sleepdeep     (sleepdeep),
    .wake_evt      (wake_evt),
    .mode_q        (mode_q),
    .lock_q        (lock_q),
    .slp_flag_q    (slp_flag_q),
    .dpd_flag_q    (dpd_flag_q),
    .req_sleep     (req_sleep),
    .req_deepsleep (req_deepsleep),
    .req_powerdown (req_powerdown),
    .req_dpd       (req_dpd)
);

// File: tb/pmu_mode_ctl_bench.sv
// Bench: sweeps all mode codes, SLEEPDEEP and lock settings, and the
// colliding-event cycles; expected values are computed from the requirements.
module pmu_mode_ctl_bench;

    localparam int          ADDR_W = 12;
    localparam int          DATA_W = 32;
    localparam logic [11:0] RA     = 12'h000;
    localparam logic [11:0] OTHER  = 12'h004;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              sys_rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = RA;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              wfi_pulse = 1'b0;
    logic              sleepdeep = 1'b0;
    logic              wake_evt = 1'b0;
    logic              req_sleep, req_deepsleep, req_powerdown, req_dpd;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pmu_mode_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(RA)) u_pmu_mode_ctl (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .wfi_pulse(wfi_pulse), .sleepdeep(sleepdeep), .wake_evt(wake_evt),
        .req_sleep(req_sleep), .req_deepsleep(req_deepsleep),
        .req_powerdown(req_powerdown), .req_dpd(req_dpd)
    );

    function automatic logic [3:0] exp_req(int m, bit sd, bit lk);
        if (!sd) return 4'b0001;
        case (m)
            1:       return 4'b0010;
            2:       return 4'b0100;
            3:       return lk ? 4'b0001 : 4'b1000;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [31:0] word(int m, bit lk, bit sf, bit df);
        return {20'd0, df, 2'b00, sf, 4'b0000, lk, m[2:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_req(string req, logic [3:0] exp);
        check(req, {28'd0, req_dpd, req_powerdown, req_deepsleep, req_sleep}, {28'd0, exp});
    endtask

    task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_addr = RA;
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        bus_addr = RA; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wfi(bit sd);
        @(negedge clk);
        wfi_pulse = 1'b1; sleepdeep = sd;
        @(negedge clk);
        wfi_pulse = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] e;
        bit sf, df;
        repeat (3) @(negedge clk);
        por_n = 1'b1; sys_rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd("R1", RA, 32'h0);
        check_req("R1", 4'b0000);

        // R9: reserved bits ignored, other address reads zero
        wr(32'hFFFF_F6F0);
        rd("R9", RA, 32'h0);
        wr(32'h0000_0002);
        rd("R9", OTHER, 32'h0);
        rd("R2", RA, 32'h2);

        // R2 R3 R6 R7 R10: full sweep with lock clear
        for (int m = 0; m < 8; m++) begin
            for (int sd = 0; sd < 2; sd++) begin
                wr(word(m, 0, 0, 0));
                wfi(sd[0]);
                e = exp_req(m, sd[0], 1'b0);
                check_req(e[3] ? "R2" : (e[0] ? "R3" : "R2"), e);
                df = e[3];
                sf = !e[3];
                rd("R6_R7", RA, word(m, 0, sf, df));
                wake();
                check_req("R10", 4'b0000);
                rd("R10", RA, word(m, 0, sf, df));
                wr(word(m, 0, 0, 0));
                rd("R6", RA, word(m, 0, sf, df));
                wr(32'h0000_0900 | m);
                rd("R7", RA, word(m, 0, 0, 0));
            end
        end

        // R8: sleep flag set collides with its clear
        wfi(1'b0);
        wake();
        @(negedge clk);
        wfi_pulse = 1'b1; sleepdeep = 1'b0;
        bus_we = 1'b1; bus_wdata = 32'h0000_0900;
        @(negedge clk);
        wfi_pulse = 1'b0; bus_we = 1'b0;
        check_req("R8", 4'b0001);
        rd("R8", RA, word(0, 0, 1, 0));
        wake();

        // R8: DPD flag set collides with its clear; sleep flag cleared
        wr(32'h3);
        wfi(1'b1);
        wake();
        @(negedge clk);
        wfi_pulse = 1'b1; sleepdeep = 1'b1;
        bus_we = 1'b1; bus_wdata = 32'h0000_0903;
        @(negedge clk);
        wfi_pulse = 1'b0; bus_we = 1'b0;
        check_req("R8", 4'b1000);
        rd("R8", RA, word(3, 0, 0, 1));
        wake();
        wr(32'h0000_0903);

        // R10: WFI in the same cycle as wake-up is ignored
        @(negedge clk);
        wfi_pulse = 1'b1; sleepdeep = 1'b1; wake_evt = 1'b1;
        @(negedge clk);
        wfi_pulse = 1'b0; wake_evt = 1'b0;
        check_req("R10", 4'b0000);
        rd("R10", RA, word(3, 0, 0, 0));

        // R10: WFI while a request is high is ignored
        wr(32'h1);
        wfi(1'b1);
        wr(32'h3);
        wfi(1'b1);
        check_req("R10", 4'b0010);
        rd("R10", RA, word(3, 0, 1, 0));
        wake();
        wr(32'h0000_0900);

        // R4 R12: lock sticky, system reset keeps retention bits
        wr(32'h3);
        wfi(1'b1);
        wake();
        wr(32'h0000_000A);
        wr(32'h0000_0002);
        rd("R4", RA, word(2, 1, 0, 1));
        wfi(1'b0);
        @(negedge clk);
        sys_rst_n = 1'b0;
        @(negedge clk);
        check_req("R12", 4'b0000);
        sys_rst_n = 1'b1;
        rd("R12", RA, word(0, 1, 0, 1));

        // R5: locked sweep over all mode codes with SLEEPDEEP set
        wr(32'h0000_0800);
        rd("R7", RA, word(0, 1, 0, 0));
        for (int m = 0; m < 8; m++) begin
            wr(word(m, 0, 0, 0));
            wfi(1'b1);
            check_req("R5", exp_req(m, 1'b1, 1'b1));
            rd("R5", RA, word(m, 1, 1, 0));
            wake();
            wr(32'h0000_0900 | m);
        end

        // R4: power-on reset clears the lock, DPD entry allowed again
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        rd("R4", RA, 32'h0);
        wr(32'h3);
        wfi(1'b1);
        check_req("R4", 4'b1000);
        rd("R7", RA, word(3, 0, 0, 1));
        wake();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule